// File: doc/BRIEF.md
# Dynamic Bus Sizing Cycle Splitter

This block sits between a 32-bit requester and an external bus whose devices report their port width on every cycle. The requester hands over one transfer with an address, a direction, write data and four active-low byte enables. The block runs a bus cycle with those enables. At each ready it samples two width flags from the device, one for an 8-bit port and one for a 16-bit port. From them it works out whether another cycle is needed and which bytes that cycle must carry. It repeats until every requested byte has moved.

Every byte stays on its own addressed lane in both directions; nothing is shifted toward the low half of the bus. On reads, each ready writes the lanes that were enabled in that cycle into a 32-bit assembly register. The assembled word is returned with a single done pulse after the last cycle. Address, direction and write data are held for the whole sequence. Only the byte enables change from one split cycle to the next.

Top module: `bus_width_splitter`

## Requirements
- R1: A request is taken on a clock edge where `req_valid_i` is high and no bus cycle is in progress (`bus_cyc_o` low). Enable bit i (active low) selects data bits 8i+7..8i. Legal patterns enable one contiguous run of lanes: 1110, 1101, 1011, 0111, 1100, 1001, 0011, 1000, 0001, 0000.
- R2: In the cycle after acceptance, `bus_cyc_o` is high and the bus carries the requested enables, address and direction.
- R3: When neither width flag is set at a ready, the transfer ends with that cycle.
- R4: With the 8-bit flag set at a ready, the next cycle's enables equal the current ones with the lowest enabled lane turned off. If no lane remains enabled, the transfer ends.
- R5: With the 16-bit flag set at a ready, another cycle follows only if lanes in both 0–1 and 2–3 are enabled. That cycle keeps only the lanes from 2–3 (enables become xx11). Otherwise the transfer ends.
- R6: When both width flags are set at the same ready, the 8-bit rule applies.
- R7: The width flags are sampled again at every ready, so consecutive split cycles may follow different rules.
- R8: Address, direction and write data on the bus stay unchanged across all split cycles of one request.
- R9: `req_done_o` is high for exactly one cycle: the cycle after the final ready. In that cycle `bus_cyc_o` is low.
- R10: For reads, each ready stores data bits 8i+7..8i into result lane i only for the lanes enabled in that cycle. Other lanes keep their earlier value, and lanes never requested read as zero. The result is valid on `req_rdata_o` while `req_done_o` is high.
- R11: On writes, every enabled lane of the bus carries the requester's byte for that same lane.
- R12: Cycles without ready change neither the enables nor the state, whatever the width flags or read data show.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe from the requester |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Transfer address |
| req_be_n_i | input | LANES | Requested byte enables, active low |
| req_wdata_i | input | 8*LANES | Write data, lane-aligned |
| req_done_o | output | 1 | One-cycle completion pulse |
| req_rdata_o | output | 8*LANES | Assembled read data |
| bus_cyc_o | output | 1 | A bus cycle is in progress |
| bus_write_o | output | 1 | Direction of the current bus cycle |
| bus_addr_o | output | ADDR_W | Address of the current bus cycle |
| bus_be_n_o | output | LANES | Byte enables of the current bus cycle, active low |
| bus_wdata_o | output | 8*LANES | Write data on the bus |
| bus_rdata_i | input | 8*LANES | Read data from the bus |
| bus_rdy_i | input | 1 | Device ends the current cycle |
| bus_w8_i | input | 1 | Device is 8 bits wide, sampled with ready |
| bus_w16_i | input | 1 | Device is 16 bits wide, sampled with ready |

## Verification
The hardest situation to reach is a device that changes width partway through one transfer. In that case the enable sequence mixes the byte rule and the half rule, and a lane can be written several times before its final value lands. The bench drives a device model that picks the width per split cycle from a schedule. The schedules alternate byte and half width in both phase orders and assert both flags at once. Every legal enable pattern is run under each schedule, for reads and writes. Wait cycles are inserted with the width flags raised and junk on the read lanes, to show that only a ready acts.

// File: rtl/bws_pkg.sv
package bws_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } bws_state_e;

    typedef enum logic [1:0] {
        PW_FULL = 2'd0,
        PW_HALF = 2'd1,
        PW_BYTE = 2'd2
    } port_width_e;

endpackage

// File: rtl/bws_next_be.sv
// Next byte-enable pattern for a port that moves GROUP lanes per cycle:
// the lowest group holding any enabled lane is retired.
module bws_next_be #(
    parameter int LANES = 4,
    parameter int GROUP = 1
) (
    input  logic [LANES-1:0] be_n_i,
    output logic [LANES-1:0] next_be_n_o,
    output logic             last_o
);
    localparam int NGRP = LANES / GROUP;

    logic             found;
    logic [LANES-1:0] next_d;

    always_comb begin
        found  = 1'b0;
        next_d = be_n_i;
        for (int g = 0; g < NGRP; g++) begin
            if (!found && !(&be_n_i[g*GROUP +: GROUP])) begin
                found                    = 1'b1;
                next_d[g*GROUP +: GROUP] = '1;
            end
        end
    end

    assign next_be_n_o = next_d;
    assign last_o      = &next_d;

endmodule

// File: rtl/bws_read_merge.sv
// Read assembly: each lane is written only when enabled in the capturing cycle.
module bws_read_merge #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               cap_i,
    input  logic [LANES-1:0]   be_n_i,
    input  logic [8*LANES-1:0] bus_data_i,
    output logic [8*LANES-1:0] data_o
);
    logic [8*LANES-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (clear_i) begin
            data_d = '0;
        end else if (cap_i) begin
            for (int i = 0; i < LANES; i++) begin
                if (!be_n_i[i]) data_d[8*i +: 8] = bus_data_i[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data_o = data_q;

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane_chk
            // R10: a lane disabled in the capturing cycle keeps its value
            a_r10_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (cap_i && !clear_i && be_n_i[gl]) |=> $stable(data_q[8*gl +: 8]));
            // R10: an enabled lane takes the bus byte of its own lane
            a_r10_lane_take: assert property (@(posedge clk) disable iff (!rst_n)
                (cap_i && !clear_i && !be_n_i[gl]) |=>
                    (data_q[8*gl +: 8] == $past(bus_data_i[8*gl +: 8])));
        end
    endgenerate

endmodule

// File: rtl/bus_width_splitter.sv
module bus_width_splitter #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [LANES-1:0]     req_be_n_i,
    input  logic [8*LANES-1:0]   req_wdata_i,
    output logic                 req_done_o,
    output logic [8*LANES-1:0]   req_rdata_o,
    output logic                 bus_cyc_o,
    output logic                 bus_write_o,
    output logic [ADDR_W-1:0]    bus_addr_o,
    output logic [LANES-1:0]     bus_be_n_o,
    output logic [8*LANES-1:0]   bus_wdata_o,
    input  logic [8*LANES-1:0]   bus_rdata_i,
    input  logic                 bus_rdy_i,
    input  logic                 bus_w8_i,
    input  logic                 bus_w16_i
);
    import bws_pkg::*;

    localparam int DATA_W = 8 * LANES;

    typedef struct packed {
        bws_state_e         state;
        logic [LANES-1:0]   be_n;
        logic [ADDR_W-1:0]  addr;
        logic               write;
        logic [DATA_W-1:0]  wdata;
        logic               done;
    } regs_t;

    regs_t d, q;

    logic [LANES-1:0] nxt8_be_n, nxt16_be_n, nxt_be_n;
    logic             last8, last16, last_w;
    port_width_e      width;
    logic             clear_w, cap_w;

    bws_next_be #(.LANES(LANES), .GROUP(1)) u_nxt8 (
        .be_n_i      (q.be_n),
        .next_be_n_o (nxt8_be_n),
        .last_o      (last8)
    );

    bws_next_be #(.LANES(LANES), .GROUP(2)) u_nxt16 (
        .be_n_i      (q.be_n),
        .next_be_n_o (nxt16_be_n),
        .last_o      (last16)
    );

    // byte width wins when both flags are raised
    always_comb begin
        if (bus_w8_i)       width = PW_BYTE;
        else if (bus_w16_i) width = PW_HALF;
        else                width = PW_FULL;
        unique case (width)
            PW_BYTE: begin nxt_be_n = nxt8_be_n;  last_w = last8;  end
            PW_HALF: begin nxt_be_n = nxt16_be_n; last_w = last16; end
            default: begin nxt_be_n = '1;         last_w = 1'b1;   end
        endcase
    end

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        clear_w = 1'b0;
        cap_w   = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.state = ST_BUS;
                    d.be_n  = req_be_n_i;
                    d.addr  = req_addr_i;
                    d.write = req_write_i;
                    d.wdata = req_wdata_i;
                    clear_w = 1'b1;
                end
            end
            ST_BUS: begin
                if (bus_rdy_i) begin
                    cap_w = !q.write;
                    if (last_w) begin
                        d.state = ST_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.be_n  = nxt_be_n;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.be_n  <= '1;
            q.addr  <= '0;
            q.write <= 1'b0;
            q.wdata <= '0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    bws_read_merge #(.LANES(LANES)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_w),
        .cap_i      (cap_w),
        .be_n_i     (q.be_n),
        .bus_data_i (bus_rdata_i),
        .data_o     (req_rdata_o)
    );

    assign bus_cyc_o   = (q.state == ST_BUS);
    assign bus_write_o = q.write;
    assign bus_addr_o  = q.addr;
    assign bus_be_n_o  = q.be_n;
    assign bus_wdata_o = q.wdata;
    assign req_done_o  = q.done;

    // one contiguous, non-empty run of enabled lanes
    function automatic logic be_legal(input logic [LANES-1:0] b);
        logic prev;
        int   edges;
        prev  = 1'b0;
        edges = 0;
        for (int i = 0; i < LANES; i++) begin
            if (!b[i] != prev) edges++;
            prev = !b[i];
        end
        if (prev) edges++;
        return edges == 2;
    endfunction

    // R1: requester presents only legal patterns when taken
    a_r1_legal_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cyc_o && req_valid_i) |-> be_legal(req_be_n_i));

    // R2: accepted request appears on the bus next cycle
    a_r2_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cyc_o && req_valid_i) |=>
            (bus_cyc_o && bus_be_n_o == $past(req_be_n_i) && bus_addr_o == $past(req_addr_i)));

    // R3: full-width port ends after one cycle
    a_r3_full_single: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_o && bus_rdy_i && !bus_w8_i && !bus_w16_i) |=> (!bus_cyc_o && req_done_o));

    // R4: a byte-wide follow-on cycle drops exactly one enabled lane
    a_r4_byte_drop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_o && bus_rdy_i && bus_w8_i && $countones(~bus_be_n_o) > 1) |=>
            (bus_cyc_o && $countones(~bus_be_n_o) == $countones(~$past(bus_be_n_o)) - 1
             && (($past(bus_be_n_o) & ~bus_be_n_o) == '0)));

    // R8: address, direction and write data frozen between split cycles
    a_r8_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_o && $past(bus_cyc_o)) |->
            ($stable(bus_addr_o) && $stable(bus_write_o) && $stable(bus_wdata_o)));

    // R9: done is a single pulse, with the bus released
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_done_o |=> !req_done_o);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_done_o |-> !bus_cyc_o);

    // R12: nothing moves while ready is low
    a_r12_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc_o && !bus_rdy_i) |=> (bus_cyc_o && $stable(bus_be_n_o) && !req_done_o));

endmodule

// File: tb/bus_width_splitter_tb_top.sv
module bus_width_splitter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_write_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [3:0]  req_be_n_i = 4'hF;
    logic [31:0] req_wdata_i = '0;
    logic        req_done_o;
    logic [31:0] req_rdata_o;
    logic        bus_cyc_o, bus_write_o;
    logic [31:0] bus_addr_o;
    logic [3:0]  bus_be_n_o;
    logic [31:0] bus_wdata_o;
    logic [31:0] bus_rdata_i = '0;
    logic        bus_rdy_i = 1'b0;
    logic        bus_w8_i = 1'b0;
    logic        bus_w16_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bus_width_splitter #(.ADDR_W(32), .LANES(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .req_be_n_i(req_be_n_i), .req_wdata_i(req_wdata_i),
        .req_done_o(req_done_o), .req_rdata_o(req_rdata_o),
        .bus_cyc_o(bus_cyc_o), .bus_write_o(bus_write_o), .bus_addr_o(bus_addr_o),
        .bus_be_n_o(bus_be_n_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
        .bus_rdy_i(bus_rdy_i), .bus_w8_i(bus_w8_i), .bus_w16_i(bus_w16_i)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // width per split cycle: 0 full, 1 byte, 2 half, 3 both flags, 4 half/byte, 5 byte/half
    function automatic void width_for(input int mode, input int k, output bit w8, output bit w16);
        w8 = 0; w16 = 0;
        case (mode)
            1: w8 = 1;
            2: w16 = 1;
            3: begin w8 = 1; w16 = 1; end
            4: if (k % 2 == 0) w16 = 1; else w8 = 1;
            5: if (k % 2 == 0) w8 = 1; else w16 = 1;
            default: ;
        endcase
    endfunction

    function automatic logic [7:0] dev_byte(input int r, input int k, input int lane);
        return 8'((r * 7) + (k * 16) + (lane * 3) + 8'h41);
    endfunction

    task automatic run_req(input int r, input logic [3:0] be, input bit wr, input int mode);
        logic [31:0] addr, wd, exp_rd;
        logic [3:0]  cur, nxt;
        bit          fin, w8, w16;
        int          k, waits;
        addr   = 32'h1000_0000 + r * 4;
        wd     = {8'(r), 8'(~r), 8'(r + 8'h5A), 8'(r ^ 8'hC3)};
        exp_rd = '0;
        @(negedge clk);
        req_valid_i = 1; req_write_i = wr; req_addr_i = addr; req_be_n_i = be; req_wdata_i = wd;
        @(negedge clk);
        req_valid_i = 0; req_addr_i = ~addr; req_wdata_i = ~wd; req_be_n_i = 4'hF;
        cur = be; k = 0; fin = 0;
        while (!fin) begin
            // R2 / R8 / R11: bus fields of split cycle k
            chk(bus_cyc_o == 1, "R2 cycle active", 32'(bus_cyc_o), 1);
            chk(bus_be_n_o == cur, (k == 0) ? "R2 first enables" : "R4/R5 next enables",
                32'(bus_be_n_o), 32'(cur));
            chk(bus_addr_o == addr && bus_write_o == wr, "R8 addr/dir held", bus_addr_o, addr);
            if (wr) begin
                for (int l = 0; l < 4; l++)
                    if (!cur[l]) chk(bus_wdata_o[8*l +: 8] == wd[8*l +: 8], "R11 write lane",
                                     32'(bus_wdata_o[8*l +: 8]), 32'(wd[8*l +: 8]));
            end
            waits = ((r + k) % 3 == 0) ? 2 : 0;
            for (int w = 0; w < waits; w++) begin
                bus_rdy_i = 0; bus_w8_i = 1; bus_w16_i = 1; bus_rdata_i = 32'hEEEE_EEEE;
                @(negedge clk);
                chk(bus_cyc_o == 1 && bus_be_n_o == cur && req_done_o == 0, "R12 wait hold",
                    32'(bus_be_n_o), 32'(cur));
            end
            width_for(mode, k, w8, w16);
            bus_rdy_i = 1; bus_w8_i = w8; bus_w16_i = w16;
            for (int l = 0; l < 4; l++) begin
                bus_rdata_i[8*l +: 8] = dev_byte(r, k, l);
                if (!cur[l]) exp_rd[8*l +: 8] = dev_byte(r, k, l);
            end
            // next pattern from R3..R6
            if (w8) begin
                nxt = cur | (cur + 4'd1);
                fin = (nxt == 4'hF);
            end else if (w16) begin
                nxt = cur | 4'b0011;
                fin = !(cur[1:0] != 2'b11 && cur[3:2] != 2'b11);
            end else begin
                nxt = 4'hF;
                fin = 1;
            end
            @(negedge clk);
            bus_rdy_i = 0; bus_w8_i = 0; bus_w16_i = 0; bus_rdata_i = 32'h5555_5555;
            if (fin) begin
                chk(req_done_o == 1 && bus_cyc_o == 0, "R9 done after last ready",
                    {30'd0, req_done_o, bus_cyc_o}, 32'h2);
                if (!wr) chk(req_rdata_o == exp_rd, "R10 assembled read", req_rdata_o, exp_rd);
            end else begin
                chk(req_done_o == 0, "R3/R4/R5 continue", 32'(req_done_o), 0);
                cur = nxt;
                k++;
            end
        end
        @(negedge clk);
        chk(req_done_o == 0, "R9 single pulse", 32'(req_done_o), 0);
    endtask

    initial begin
        logic [3:0] pats [10];
        int r;
        pats = '{4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b1100,
                 4'b1001, 4'b0011, 4'b1000, 4'b0001, 4'b0000};
        repeat (3) @(negedge clk);
        chk(bus_cyc_o == 0 && req_done_o == 0, "R9 reset idle", 32'(bus_cyc_o), 0);
        chk(req_rdata_o == 0, "R10 reset result", req_rdata_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk(bus_cyc_o == 0, "R1 idle without valid", 32'(bus_cyc_o), 0);
        r = 0;
        for (int m = 0; m < 6; m++)
            for (int p = 0; p < 10; p++)
                for (int wr = 0; wr < 2; wr++) begin
                    // R1 R3 R4 R5 R6 R7 swept here
                    run_req(r, pats[p], wr[0], m);
                    r++;
                end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule